// File: doc/BRIEF.md
# Multiplexed LCD row and key-scan sequencer

This block runs from the oscillator clock and steps a segment LCD through its common rows at a duty of 1/2, 1/3 or 1/4. Each row slot ends with a 16-clock key-scan window. For every common line and every one of the 56 segment lines it produces a 3-bit drive-level code. An analog stage elsewhere turns each code into a voltage.

The codes follow the bias that the duty implies. A selected common and the lit segments swap polarity on every frame, so the display sees no net DC. During the key windows, the first eight segment lines take turns acting as key sources, and once per frame a one-cycle strobe marks the point at which all eight sources have been driven.

The block also handles three overrides. An output-enable pin forces every line to the top rail. A display-enable input blanks the segments and stops key scanning. A mode pin turns the top eight segment lines into LED drives. The row pattern comes from an external latch of four 56-bit rows.

Top module: `lcd_scan_timer`

## Requirements
- R1: While reset is held, the sequencer is at row 0, clock 0 of the slot, with positive polarity. With 1/4 duty, all enables high and all row data zero: common 0 reads code 4, commons 1 to 3 read code 1, every segment reads code 3, and `key_strobe` and `led_on` are 0.
- R2: `duty_sel` selects the number of rows: 0 gives 4 rows, 1 gives 3 rows, and 2 or 3 give 2 rows. A slot lasts 128 << `div_sel` clocks and a frame lasts rows × slot clocks. Consecutive key strobes are a whole number of frames apart.
- R3: With 3 or 4 rows (1/3 bias), while outside a key window and with positive polarity:
  - the selected common is 4 and the other active commons are 1;
  - a lit segment is 0 and an unlit segment is 3.
- R4: With 2 rows (1/2 bias), while outside a key window and with positive polarity:
  - the selected common is 4 and the other active common is 2;
  - a lit segment is 0 and an unlit segment is 4.
  - Commons beyond the active row count read 0 whenever output enable is high.
- R5: Polarity starts positive after reset or a restart and inverts at every frame boundary. With negative polarity every code in R3 and R4 becomes its mirror: 4↔0, 1↔3, and 2 stays 2.
- R6: The last 16 clocks of each slot form the key window. In it, active commons read 2 and every segment that is not an asserted key source reads 0.
- R7: The key window is split into eight 2-clock sub-slots, numbered j = 0..7. Key sources are driven only while both display enable and output enable are high; an asserted source reads code 4.
  - In the window of row 0, segment j is a key source for j = 4..7.
  - In the window of the last row, segment j is a key source for j = 0..3.
  - No other window drives a source.
- R8: `key_strobe` is high for exactly the last clock of row 0's slot, and only while both display enable and output enable are high.
- R9: With `out_en` low, every common and segment code is 4 and all LED drives are off. The sequencer keeps running.
- R10: With `disp_on` low, every segment shows its unlit level whatever the row data, no key source is driven, and the strobe and LEDs stay off.
- R11: With `lcd_sel` low, segments 48 to 55 read code 0. `led_on[i]` is then 1 exactly when output enable and display enable are high and row 0 bit 48+i is 0; row data uses 1 for lit and, for an LED, 0 for on.
- R12: A change on `duty_sel` or `div_sel` restarts the sequencer at the next clock, at row 0, clock 0, with positive polarity.

Level codes: 0 = ground, 1 = one third, 2 = half, 3 = two thirds, 4 = top rail. Common c sits at bits [3c+2:3c] of `com_lvl` and segment s at bits [3s+2:3s] of `seg_lvl`. Row r, segment s is bit r*56+s of `rows`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_sel | input | 2 | Row count select (R2) |
| div_sel | input | 2 | Slot length select, 128 << value clocks |
| disp_on | input | 1 | Display and key-scan enable |
| out_en | input | 1 | Output enable; low forces all lines to top rail |
| lcd_sel | input | 1 | High: all segment lines drive the LCD; low: top eight lines drive LEDs |
| rows | input | 224 | Four 56-bit row patterns from the display latch |
| com_lvl | output | 12 | Drive-level code per common |
| seg_lvl | output | 168 | Drive-level code per segment |
| led_on | output | 8 | LED drive on, per LED line |
| key_strobe | output | 1 | One-cycle key sample strobe per frame |

## Verification
The assertions assume the configuration inputs stay put between deliberate changes, so that the slot counter steps by one except at slot ends or restarts. They also assume `out_en` and `disp_on` are synchronous to the clock. The bench changes every input just after a rising edge and holds each configuration for several frames. It drives one configuration per supported duty and several slot lengths, covers every key window and polarity, and also exercises output-enable drops, blanking and LED mode.

// File: rtl/lcd_scan_timer.sv
`timescale 1ns/1ps
module lcd_scan_timer #(
  parameter int NSEG     = 56,
  parameter int NCOM     = 4,
  parameter int NKEY     = 8,
  parameter int NLED     = 8,
  parameter int SLOT_MIN = 128,
  parameter int KWIN     = 16,
  parameter int MAXSH    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           duty_sel,
  input  logic [1:0]           div_sel,
  input  logic                 disp_on,
  input  logic                 out_en,
  input  logic                 lcd_sel,
  input  logic [NCOM*NSEG-1:0] rows,
  output logic [NCOM*3-1:0]    com_lvl,
  output logic [NSEG*3-1:0]    seg_lvl,
  output logic [NLED-1:0]      led_on,
  output logic                 key_strobe
);
  localparam int CW   = $clog2(SLOT_MIN) + MAXSH;
  localparam int SW   = $clog2(NCOM);
  localparam int KW   = $clog2(NKEY);
  localparam int SUBC = KWIN / NKEY;
  localparam logic [2:0] LV_0 = 3'd0, LV_13 = 3'd1, LV_12 = 3'd2, LV_23 = 3'd3, LV_F = 3'd4;

  logic [1:0]      duty_q, div_q;
  logic [CW-1:0]   cnt;
  logic [SW-1:0]   slot;
  logic            pol;
  logic [CW:0]     slot_len, kofs;
  logic [SW:0]     ncom;
  logic [KW-1:0]   sub;
  logic [NSEG-1:0] row_cur;
  logic            restart, slot_end, last_slot, frame_end, in_key, scan_act, src_ok, bias13;

  assign ncom      = (duty_q == 2'd0) ? (SW+1)'(NCOM) :
                     (duty_q == 2'd1) ? (SW+1)'(NCOM-1) : (SW+1)'(NCOM-2);
  assign bias13    = ~duty_q[1];
  assign slot_len  = (CW+1)'(SLOT_MIN) << div_q;
  assign restart   = (duty_sel != duty_q) || (div_sel != div_q);
  assign slot_end  = ({1'b0, cnt} == slot_len - 1'b1);
  assign last_slot = ({1'b0, slot} == ncom - 1'b1);
  assign frame_end = slot_end & last_slot;
  assign in_key    = {1'b0, cnt} >= slot_len - (CW+1)'(KWIN);
  assign kofs      = {1'b0, cnt} - (slot_len - (CW+1)'(KWIN));
  assign sub       = KW'(kofs / (CW+1)'(SUBC));
  assign scan_act  = disp_on & out_en;
  assign src_ok    = scan_act & in_key &
                     (((slot == '0) && (sub >= KW'(NKEY/2))) ||
                      (last_slot && (sub < KW'(NKEY/2))));
  assign row_cur   = rows[slot*NSEG +: NSEG];
  assign key_strobe = scan_act & (slot == '0) & slot_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      div_q  <= '0;
      cnt    <= '0;
      slot   <= '0;
      pol    <= 1'b0;
    end else if (restart) begin
      duty_q <= duty_sel;
      div_q  <= div_sel;
      cnt    <= '0;
      slot   <= '0;
      pol    <= 1'b0;
    end else if (slot_end) begin
      cnt <= '0;
      if (last_slot) begin
        slot <= '0;
        pol  <= ~pol;
      end else begin
        slot <= slot + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    logic [2:0] lv;
    always_comb begin
      if (!out_en)                      lv = LV_F;
      else if ((SW+1)'(c) >= ncom)      lv = LV_0;
      else if (in_key)                  lv = LV_12;
      else if (slot == SW'(c))          lv = pol ? LV_0 : LV_F;
      else if (bias13)                  lv = pol ? LV_23 : LV_13;
      else                              lv = LV_12;
    end
    assign com_lvl[c*3 +: 3] = lv;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam bit IS_LED = (s >= NSEG - NLED);
    localparam bit IS_KEY = (s < NKEY);
    logic [2:0] lv;
    always_comb begin
      if (!out_en)                      lv = LV_F;
      else if (IS_LED && !lcd_sel)      lv = LV_0;
      else if (in_key)                  lv = (IS_KEY && src_ok && (sub == KW'(s))) ? LV_F : LV_0;
      else if (disp_on && row_cur[s])   lv = pol ? LV_F : LV_0;
      else if (bias13)                  lv = pol ? LV_13 : LV_23;
      else                              lv = pol ? LV_0 : LV_F;
    end
    assign seg_lvl[s*3 +: 3] = lv;
  end

  for (genvar i = 0; i < NLED; i++) begin : g_led
    assign led_on[i] = out_en & disp_on & ~lcd_sel & ~rows[NSEG-NLED+i];
  end
endmodule

module lcd_scan_timer_chk #(
  parameter int NSEG = 56,
  parameter int NCOM = 4,
  parameter int NLED = 8,
  parameter int CW   = 10,
  parameter int SW   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_en,
  input logic              disp_on,
  input logic              key_strobe,
  input logic              restart,
  input logic              slot_end,
  input logic              frame_end,
  input logic              pol,
  input logic [CW-1:0]     cnt,
  input logic [SW-1:0]     slot,
  input logic [NCOM*3-1:0] com_lvl,
  input logic [NSEG*3-1:0] seg_lvl,
  input logic [NLED-1:0]   led_on
);
  logic [NCOM-1:0] com_full;
  for (genvar c = 0; c < NCOM; c++) begin : g_cf
    assign com_full[c] = (com_lvl[c*3 +: 3] == 3'd4);
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !slot_end) |=> (cnt == $past(cnt) + 1'b1));
  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && slot_end) |=> (cnt == '0));
  a_r3_one_com_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> $onehot0(com_full));
  a_r5_pol_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && frame_end) |=> (pol != $past(pol)));
  a_r5_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !frame_end) |=> (pol == $past(pol)));
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    key_strobe |=> !key_strobe);
  a_r9_oe_all_full: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> ((com_lvl == {NCOM{3'd4}}) && (seg_lvl == {NSEG{3'd4}}) && (led_on == '0) && !key_strobe));
  a_r10_off_no_led: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> ((led_on == '0) && !key_strobe));
  a_r12_restart_home: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ((cnt == '0) && (slot == '0) && !pol));
endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(.NSEG(NSEG), .NCOM(NCOM), .NLED(NLED), .CW(CW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_en(out_en), .disp_on(disp_on), .key_strobe(key_strobe),
  .restart(restart), .slot_end(slot_end), .frame_end(frame_end), .pol(pol), .cnt(cnt),
  .slot(slot), .com_lvl(com_lvl), .seg_lvl(seg_lvl), .led_on(led_on)
);

// File: tb/tb_lcd_scan_timer.sv
`timescale 1ns/1ps
module tb_lcd_scan_timer;
  localparam int NSEG = 56, NCOM = 4, NLED = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] duty_sel = 2'd0, div_sel = 2'd0;
  logic disp_on = 1'b1, out_en = 1'b1, lcd_sel = 1'b1, run_chk = 1'b0, done = 1'b0;
  logic [NCOM*NSEG-1:0] rows = '0;
  logic [NCOM*3-1:0] com_lvl;
  logic [NSEG*3-1:0] seg_lvl;
  logic [NLED-1:0] led_on;
  logic key_strobe;

  lcd_scan_timer dut (
    .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .div_sel(div_sel), .disp_on(disp_on),
    .out_en(out_en), .lcd_sel(lcd_sel), .rows(rows), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .led_on(led_on), .key_strobe(key_strobe)
  );

  int total = 0, bad = 0, restarts = 0, rt = 0;
  longint cyc = 0, last_sb = -1;
  logic [1:0] rd = 2'd0, rv = 2'd0;

  // clocks since the last restart, per R12
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt <= 0; rd <= 2'd0; rv <= 2'd0;
    end else if (duty_sel != rd || div_sel != rv) begin
      rt <= 0; rd <= duty_sel; rv <= div_sel; restarts <= restarts + 1;
    end else begin
      rt <= rt + 1;
    end
  end

  task automatic chk(input string tag, input string what, input logic [NSEG*3-1:0] act, input logic [NSEG*3-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int n, L, pos, sl, c, sub;
    bit pol, ink, b13, sc, srcv, estb;
    logic [NCOM*3-1:0] ec;
    logic [NSEG*3-1:0] es;
    logic [NLED-1:0] el;
    string tc, ts;
    cyc++;
    if (rst_n && run_chk) begin
      n   = (rd == 2'd0) ? 4 : (rd == 2'd1) ? 3 : 2;
      L   = 128 << rv;
      pos = rt % (n * L);
      pol = ((rt / (n * L)) % 2) == 1;
      sl  = pos / L;
      c   = pos % L;
      ink = c >= L - 16;
      sub = (c - (L - 16)) / 2;
      b13 = rd < 2;
      sc  = disp_on && out_en;
      srcv = ink && sc && ((sl == 0 && sub >= 4) || (sl == n - 1 && sub < 4));
      for (int k = 0; k < NCOM; k++) begin
        if (!out_en)     ec[k*3 +: 3] = 3'd4;
        else if (k >= n) ec[k*3 +: 3] = 3'd0;
        else if (ink)    ec[k*3 +: 3] = 3'd2;
        else if (k == sl) ec[k*3 +: 3] = pol ? 3'd0 : 3'd4;
        else             ec[k*3 +: 3] = b13 ? (pol ? 3'd3 : 3'd1) : 3'd2;
      end
      for (int s = 0; s < NSEG; s++) begin
        if (!out_en)                     es[s*3 +: 3] = 3'd4;
        else if (s >= 48 && !lcd_sel)    es[s*3 +: 3] = 3'd0;
        else if (ink)                    es[s*3 +: 3] = (srcv && s == sub) ? 3'd4 : 3'd0;
        else if (disp_on && rows[sl*NSEG + s]) es[s*3 +: 3] = pol ? 3'd4 : 3'd0;
        else if (b13)                    es[s*3 +: 3] = pol ? 3'd1 : 3'd3;
        else                             es[s*3 +: 3] = pol ? 3'd0 : 3'd4;
      end
      for (int i = 0; i < NLED; i++) el[i] = out_en && disp_on && !lcd_sel && !rows[48 + i];
      estb = sc && sl == 0 && c == L - 1;

      if (restarts > 0 && rt < 2) tc = "R12";
      else if (!out_en) tc = "R9";
      else if (ink)     tc = "R6";
      else if (pol)     tc = "R5";
      else if (b13)     tc = "R3";
      else              tc = "R4";
      if (!out_en)      ts = "R9";
      else if (ink)     ts = srcv ? "R7" : "R6";
      else if (!disp_on) ts = "R10";
      else if (pol)     ts = "R5";
      else if (b13)     ts = "R3";
      else              ts = "R4";

      chk(tc, "com_lvl", {{(NSEG*3-NCOM*3){1'b0}}, com_lvl}, {{(NSEG*3-NCOM*3){1'b0}}, ec});
      chk(ts, "seg_lvl", seg_lvl, es);
      chk("R11", "led_on", {{(NSEG*3-NLED){1'b0}}, led_on}, {{(NSEG*3-NLED){1'b0}}, el});
      chk("R8", "key_strobe", {{(NSEG*3-1){1'b0}}, key_strobe}, {{(NSEG*3-1){1'b0}}, estb});

      if (rt == 0) last_sb = -1;
      if (key_strobe) begin
        if (last_sb >= 0)
          chk("R2", "strobe spacing mod frame", (NSEG*3)'((cyc - last_sb) % (n * L)), '0);
        last_sb = cyc;
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int dl[8] = '{0, 1, 2, 3, 0, 1, 2, 0};
    int vl[8] = '{0, 0, 0, 1, 1, 1, 3, 2};
    logic [NSEG*3-1:0] r1seg;
    repeat (3) @(negedge clk);
    // R1: home state during reset
    r1seg = '0;
    for (int s = 0; s < NSEG; s++) r1seg[s*3 +: 3] = 3'd3;
    chk("R1", "reset com_lvl", {{(NSEG*3-NCOM*3){1'b0}}, com_lvl}, {{(NSEG*3-12){1'b0}}, 12'o1114});
    chk("R1", "reset seg_lvl", seg_lvl, r1seg);
    chk("R1", "reset strobe/led", {{(NSEG*3-9){1'b0}}, led_on, key_strobe}, '0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    run_chk = 1'b1;
    for (int k = 0; k < 8; k++) begin
      int n, fl;
      n  = (dl[k] == 0) ? 4 : (dl[k] == 1) ? 3 : 2;
      fl = n * (128 << vl[k]);
      duty_sel = 2'(dl[k]);
      div_sel  = 2'(vl[k]);
      for (int i = 0; i < NCOM*NSEG; i++) rows[i] = ((i * 7 + k * 13 + i / 5) % 3) == 0;
      disp_on = 1'b1; out_en = 1'b1; lcd_sel = 1'b1;
      run(2 * fl + 37);
      lcd_sel = 1'b0;
      run(fl / 2);
      disp_on = 1'b0;
      run(fl / 2 + 5);
      disp_on = 1'b1; lcd_sel = 1'b1; out_en = 1'b0;
      run(fl / 3);
      out_en = 1'b1;
      run(fl + 11);
    end
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
    end
  end
endmodule